// File: doc/BRIEF.md
# Framebuffer Rasterizer Command Engine

This block draws simple primitives into a write-only framebuffer of 214 by 160 pixels, with 3 bits of colour per pixel. It works next to a processor. The processor hands over one command at a time, made of a subcode, two corner points and an 8-bit immediate that carries the colour. The engine then walks every affected pixel on its own, one pixel per clock, and drives a pixel write port with a linear address, a colour and a write strobe. The processor keeps executing meanwhile and polls the `busy` output to learn when the drawing has finished.

There are four primitives: clear the whole screen, plot a single point, draw a line between two points, and fill a rectangle. Rectangles accept their corners in either order. Lines use an integer error-accumulating walk that covers every direction. The engine visits positions outside the visible area like any other position but never writes them, so off-screen geometry only costs cycles.

Top module: `rast_engine`

## Requirements
- R1: After reset, `busy` and `pix_we` are both low.
- R2: When `cmd_valid` is high and `busy` is low at a rising edge, a subcode with bit 2 clear (000 clear, 001 point, 010 line, 011 rectangle) is captured and `busy` is high from the next cycle. Subcodes 100 to 111 are ignored: `busy` stays low and nothing is written.
- R3: A `cmd_valid` that arrives while `busy` is high is ignored. The running command keeps its pixels and colour, and no further command starts after it.
- R4: Every write uses address y*214 + x. The colour is bits [2:0] of `cmd_imm`, and bits [7:3] have no effect.
- R5: A point command at (x0,y0) keeps `busy` high for exactly one cycle and writes that pixel exactly once.
- R6: The clear command writes addresses 0 to 34239 in ascending order, once each, and keeps `busy` high for 34240 cycles.
- R7: A rectangle command writes the inclusive region between min(x0,x1)..max(x0,x1) and min(y0,y1)..max(y0,y1) in row-major order, and keeps `busy` high for one cycle per position. Swapping the corners gives the same writes.
- R8: A line command visits max(|x1-x0|,|y1-y0|)+1 positions, one per busy cycle. The first is (x0,y0) and the last is (x1,y1). Each step moves exactly one pixel along the longer axis and at most one pixel along the other.
- R9: A position with x >= 214 or y >= 160 is never written, but it still takes its busy cycle.
- R10: `pix_we` is high only while `busy` is high, and at most one pixel is written per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Primitive subcode |
| cmd_x0 | input | 8 | First corner, x |
| cmd_y0 | input | 8 | First corner, y |
| cmd_x1 | input | 8 | Second corner, x |
| cmd_y1 | input | 8 | Second corner, y |
| cmd_imm | input | 8 | Immediate; low 3 bits give the colour |
| busy | output | 1 | High while a command is being drawn |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | 16 | Linear pixel address |
| pix_color | output | 3 | Pixel colour |

## Verification
A wrong walker state shows up on `pix_addr` in the very next busy cycle. A mis-stepped line breaks the rule of one-pixel moves, or it misses its end point and leaves `busy` high for the wrong number of cycles. A bad clip or bad address shows as a write outside the 34240-entry range or at a position that the reference order does not expect, and this is visible on the same clock as the write. Errors in capture or busy appear within one cycle of the strobe: `busy` rises on a reserved subcode, or a second command is taken while one is still running.

// File: rtl/rast_pkg.sv
`timescale 1ns/1ps
package rast_pkg;
   localparam logic [2:0] OP_CLEAR = 3'b000;
   localparam logic [2:0] OP_POINT = 3'b001;
   localparam logic [2:0] OP_LINE  = 3'b010;
   localparam logic [2:0] OP_BOX   = 3'b011;

   typedef enum logic {
      WALK_SCAN = 1'b0,
      WALK_LINE = 1'b1
   } walk_kind_t;
endpackage

// File: rtl/rast_addr_gen.sv
`timescale 1ns/1ps
module rast_addr_gen #(
   parameter int FB_W = 214,
   parameter int FB_H = 160,
   parameter int CW   = 8,
   parameter int AW   = 16
) (
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   output logic [AW-1:0] addr,
   output logic          on_screen
);
   localparam bit W_POW2 = (FB_W & (FB_W - 1)) == 0;

   assign on_screen = (int'(x) < FB_W) && (int'(y) < FB_H);

   generate
      if (W_POW2) begin : g_shift
         localparam int XB = $clog2(FB_W);
         assign addr = AW'({y, x[XB-1:0]});
      end else begin : g_mult
         assign addr = AW'(y) * AW'(FB_W) + AW'(x);
      end
   endgenerate
endmodule

// File: rtl/rast_scan_walker.sv
`timescale 1ns/1ps
module rast_scan_walker #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [CW-1:0] x_lo,
   input  logic [CW-1:0] x_hi,
   input  logic [CW-1:0] y_lo,
   input  logic [CW-1:0] y_hi,
   output logic [CW-1:0] cur_x,
   output logic [CW-1:0] cur_y,
   output logic          at_end
);
   logic [CW-1:0] xlo_q, xhi_q, yhi_q;

   assign at_end = (cur_x == xhi_q) && (cur_y == yhi_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_x <= '0;
         cur_y <= '0;
         xlo_q <= '0;
         xhi_q <= '0;
         yhi_q <= '0;
      end else if (load) begin
         cur_x <= x_lo;
         cur_y <= y_lo;
         xlo_q <= x_lo;
         xhi_q <= x_hi;
         yhi_q <= y_hi;
      end else if (step) begin
         if (cur_x == xhi_q) begin
            cur_x <= xlo_q;
            cur_y <= cur_y + CW'(1);
         end else begin
            cur_x <= cur_x + CW'(1);
         end
      end
   end
endmodule

// File: rtl/rast_line_walker.sv
`timescale 1ns/1ps
module rast_line_walker #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [CW-1:0] x_a,
   input  logic [CW-1:0] y_a,
   input  logic [CW-1:0] x_b,
   input  logic [CW-1:0] y_b,
   output logic [CW-1:0] cur_x,
   output logic [CW-1:0] cur_y,
   output logic          at_end
);
   localparam int EW = CW + 4;

   logic signed [EW-1:0] ddx, ddy, adx, ady;
   logic signed [EW-1:0] span_x_q, span_y_q, err_q;
   logic signed [EW-1:0] e2, nerr;
   logic [CW-1:0]        xb_q, yb_q, nx, ny;
   logic                 xneg_q, yneg_q;

   always_comb begin
      ddx = EW'(x_b) - EW'(x_a);
      ddy = EW'(y_b) - EW'(y_a);
      adx = ddx[EW-1] ? -ddx : ddx;
      ady = ddy[EW-1] ? -ddy : ddy;
   end

   always_comb begin
      e2   = err_q <<< 1;
      nerr = err_q;
      nx   = cur_x;
      ny   = cur_y;
      if (e2 >= span_y_q) begin
         nerr = nerr + span_y_q;
         nx   = xneg_q ? cur_x - CW'(1) : cur_x + CW'(1);
      end
      if (e2 <= span_x_q) begin
         nerr = nerr + span_x_q;
         ny   = yneg_q ? cur_y - CW'(1) : cur_y + CW'(1);
      end
   end

   assign at_end = (cur_x == xb_q) && (cur_y == yb_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_x    <= '0;
         cur_y    <= '0;
         xb_q     <= '0;
         yb_q     <= '0;
         span_x_q <= '0;
         span_y_q <= '0;
         err_q    <= '0;
         xneg_q   <= 1'b0;
         yneg_q   <= 1'b0;
      end else if (load) begin
         cur_x    <= x_a;
         cur_y    <= y_a;
         xb_q     <= x_b;
         yb_q     <= y_b;
         span_x_q <= adx;
         span_y_q <= -ady;
         err_q    <= adx - ady;
         xneg_q   <= ddx[EW-1];
         yneg_q   <= ddy[EW-1];
      end else if (step) begin
         cur_x <= nx;
         cur_y <= ny;
         err_q <= nerr;
      end
   end
endmodule

// File: rtl/rast_engine.sv
`timescale 1ns/1ps
module rast_engine #(
   parameter int FB_W = 214,
   parameter int FB_H = 160,
   parameter int CW   = 8,
   parameter int COLW = 3,
   parameter int IMMW = 8,
   parameter int AW   = $clog2(FB_W * FB_H)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [2:0]      cmd_op,
   input  logic [CW-1:0]   cmd_x0,
   input  logic [CW-1:0]   cmd_y0,
   input  logic [CW-1:0]   cmd_x1,
   input  logic [CW-1:0]   cmd_y1,
   input  logic [IMMW-1:0] cmd_imm,
   output logic            busy,
   output logic            pix_we,
   output logic [AW-1:0]   pix_addr,
   output logic [COLW-1:0] pix_color
);
   import rast_pkg::*;

   generate
      if (FB_W < 2 || FB_W > (1 << CW)) begin : g_bad_width
         $error("rast_engine: FB_W must lie in 2..2**CW");
      end
      if (FB_H < 1 || FB_H > (1 << CW)) begin : g_bad_height
         $error("rast_engine: FB_H must lie in 1..2**CW");
      end
      if (COLW > IMMW) begin : g_bad_color
         $error("rast_engine: colour field wider than immediate");
      end
      if ((1 << AW) < FB_W * FB_H) begin : g_bad_addr
         $error("rast_engine: AW too narrow for the framebuffer");
      end
   endgenerate

   localparam logic [CW-1:0] X_LAST = CW'(FB_W - 1);
   localparam logic [CW-1:0] Y_LAST = CW'(FB_H - 1);

   logic            busy_q;
   walk_kind_t      kind_q;
   logic [COLW-1:0] color_q;
   logic            accept, scan_load, line_load, walk_step, walk_end;
   logic [CW-1:0]   sx_lo, sx_hi, sy_lo, sy_hi;
   logic [CW-1:0]   scan_x, scan_y, line_x, line_y, px, py;
   logic            scan_end, line_end, on_screen;
   logic            unused_imm_hi;

   assign unused_imm_hi = ^cmd_imm;

   // capture only the four defined primitives, and only when idle
   assign accept    = cmd_valid && !busy_q && !cmd_op[2];
   assign line_load = accept && (cmd_op == OP_LINE);
   assign scan_load = accept && (cmd_op != OP_LINE);

   always_comb begin
      sx_lo = cmd_x0;
      sx_hi = cmd_x0;
      sy_lo = cmd_y0;
      sy_hi = cmd_y0;
      case (cmd_op)
         OP_CLEAR: begin
            sx_lo = '0;
            sx_hi = X_LAST;
            sy_lo = '0;
            sy_hi = Y_LAST;
         end
         OP_BOX: begin
            sx_lo = (cmd_x0 < cmd_x1) ? cmd_x0 : cmd_x1;
            sx_hi = (cmd_x0 < cmd_x1) ? cmd_x1 : cmd_x0;
            sy_lo = (cmd_y0 < cmd_y1) ? cmd_y0 : cmd_y1;
            sy_hi = (cmd_y0 < cmd_y1) ? cmd_y1 : cmd_y0;
         end
         default: ;
      endcase
   end

   rast_scan_walker #(.CW(CW)) u_scan (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (scan_load),
      .step   (walk_step && kind_q == WALK_SCAN),
      .x_lo   (sx_lo),
      .x_hi   (sx_hi),
      .y_lo   (sy_lo),
      .y_hi   (sy_hi),
      .cur_x  (scan_x),
      .cur_y  (scan_y),
      .at_end (scan_end)
   );

   rast_line_walker #(.CW(CW)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (line_load),
      .step   (walk_step && kind_q == WALK_LINE),
      .x_a    (cmd_x0),
      .y_a    (cmd_y0),
      .x_b    (cmd_x1),
      .y_b    (cmd_y1),
      .cur_x  (line_x),
      .cur_y  (line_y),
      .at_end (line_end)
   );

   assign px        = (kind_q == WALK_LINE) ? line_x : scan_x;
   assign py        = (kind_q == WALK_LINE) ? line_y : scan_y;
   assign walk_end  = (kind_q == WALK_LINE) ? line_end : scan_end;
   assign walk_step = busy_q && !walk_end;

   rast_addr_gen #(.FB_W(FB_W), .FB_H(FB_H), .CW(CW), .AW(AW)) u_addr (
      .x         (px),
      .y         (py),
      .addr      (pix_addr),
      .on_screen (on_screen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         kind_q  <= WALK_SCAN;
         color_q <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         kind_q  <= (cmd_op == OP_LINE) ? WALK_LINE : WALK_SCAN;
         color_q <= cmd_imm[COLW-1:0];
      end else if (busy_q && walk_end) begin
         busy_q  <= 1'b0;
      end
   end

   assign busy      = busy_q;
   assign pix_we    = busy_q && on_screen;
   assign pix_color = color_q;
endmodule

// File: rtl/rast_engine_chk.sv
`timescale 1ns/1ps
module rast_engine_chk #(
   parameter int FB_W = 214,
   parameter int FB_H = 160,
   parameter int COLW = 3,
   parameter int AW   = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [2:0]      cmd_op,
   input logic            busy,
   input logic            pix_we,
   input logic [AW-1:0]   pix_addr,
   input logic [COLW-1:0] pix_color
);
   localparam int NPIX = FB_W * FB_H;

   a_r10_we_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      pix_we |-> busy);

   a_r9_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pix_we |-> (int'(pix_addr) < NPIX));

   a_r2_busy_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_valid) && !$past(cmd_op[2])));

   a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && cmd_op[2]) |=> !busy);

   a_r3_color_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pix_color));

   a_r5_point_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(cmd_op) == 3'b001) |=> !busy);

   a_r6_clear_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && $past(cmd_op) == 3'b000) |-> (pix_we && pix_addr == '0));
endmodule

bind rast_engine rast_engine_chk #(
   .FB_W (FB_W),
   .FB_H (FB_H),
   .COLW (COLW),
   .AW   (AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .busy      (busy),
   .pix_we    (pix_we),
   .pix_addr  (pix_addr),
   .pix_color (pix_color)
);

// File: tb/tb_rast_engine.sv
`timescale 1ns/1ps
module tb_rast_engine;
   localparam int W = 214;
   localparam int H = 160;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [7:0]  cmd_x0 = '0, cmd_y0 = '0, cmd_x1 = '0, cmd_y1 = '0;
   logic [7:0]  cmd_imm = '0;
   logic        busy, pix_we;
   logic [15:0] pix_addr;
   logic [2:0]  pix_color;

   int n_checks = 0;
   int n_errors = 0;
   int wq[$];
   int cyc;
   int colbad;

   always #10 clk = ~clk;

   rast_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_x0(cmd_x0), .cmd_y0(cmd_y0), .cmd_x1(cmd_x1), .cmd_y1(cmd_y1),
      .cmd_imm(cmd_imm), .busy(busy), .pix_we(pix_we), .pix_addr(pix_addr),
      .pix_color(pix_color)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction

   // issue one command, then collect its writes until busy drops;
   // between cycles intr_from..intr_to-1 a foreign point strobe is held
   task automatic run_cmd(input logic [2:0] op, input int x0, input int y0,
                          input int x1, input int y1, input logic [7:0] imm,
                          input int intr_from, input int intr_to);
      wq.delete();
      cyc = 0;
      colbad = 0;
      @(negedge clk);
      cmd_op = op; cmd_x0 = 8'(x0); cmd_y0 = 8'(y0);
      cmd_x1 = 8'(x1); cmd_y1 = 8'(y1); cmd_imm = imm;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (busy && cyc < 70000) begin
         if (cyc == intr_from) begin
            cmd_valid = 1'b1; cmd_op = 3'b001;
            cmd_x0 = 8'd0; cmd_y0 = 8'd0; cmd_imm = 8'h02;
         end
         if (cyc == intr_to) cmd_valid = 1'b0;
         if (pix_we) begin
            wq.push_back(int'(pix_addr));
            if (pix_color != imm[2:0]) colbad++;
         end
         cyc++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(pix_we == 1'b0, "R1 pix_we after reset", int'(pix_we), 0);
   endtask

   task automatic t_point;
      run_cmd(3'b001, 7, 3, 90, 90, 8'hF9, -1, -1);
      chk(cyc == 1, "R5 point busy cycles", cyc, 1);
      chk(wq.size() == 1, "R5 point write count", wq.size(), 1);
      if (wq.size() > 0) chk(wq[0] == 3 * W + 7, "R4 point address", wq[0], 3 * W + 7);
      chk(colbad == 0, "R4 colour from imm low bits", colbad, 0);
      run_cmd(3'b001, 213, 159, 0, 0, 8'h06, -1, -1);
      chk(wq.size() == 1, "R5 corner point write count", wq.size(), 1);
      if (wq.size() > 0) chk(wq[0] == 159 * W + 213, "R4 last address", wq[0], 159 * W + 213);
   endtask

   task automatic t_reserved;
      int bad = 0;
      @(negedge clk);
      cmd_op = 3'b110; cmd_x0 = 8'd1; cmd_y0 = 8'd1; cmd_imm = 8'h07;
      cmd_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cmd_valid = 1'b0;
         if (busy || pix_we) bad++;
      end
      chk(bad == 0, "R2 reserved subcode ignored", bad, 0);
      chk(pix_we == 1'b0 && busy == 1'b0, "R10 no write while idle", int'(pix_we), 0);
   endtask

   task automatic t_rect(input int x0, input int y0, input int x1, input int y1);
      int xl = (x0 < x1) ? x0 : x1;
      int xh = (x0 < x1) ? x1 : x0;
      int yl = (y0 < y1) ? y0 : y1;
      int yh = (y0 < y1) ? y1 : y0;
      int n = (xh - xl + 1) * (yh - yl + 1);
      int k = 0;
      int mism = 0;
      run_cmd(3'b011, x0, y0, x1, y1, 8'h0D, -1, -1);
      chk(cyc == n, "R7 rect busy cycles", cyc, n);
      chk(wq.size() == n, "R7 rect write count", wq.size(), n);
      for (int y = yl; y <= yh; y++)
         for (int x = xl; x <= xh; x++) begin
            if (k < wq.size() && wq[k] != y * W + x) mism++;
            k++;
         end
      chk(mism == 0, "R7 rect row-major addresses", mism, 0);
      chk(colbad == 0, "R4 rect colour", colbad, 0);
   endtask

   task automatic t_clip;
      int exp[4] = '{158 * W + 212, 158 * W + 213, 159 * W + 212, 159 * W + 213};
      int mism = 0;
      run_cmd(3'b011, 215, 161, 212, 158, 8'h03, -1, -1);
      chk(cyc == 16, "R9 clipped rect busy cycles", cyc, 16);
      chk(wq.size() == 4, "R9 clipped rect writes", wq.size(), 4);
      for (int i = 0; i < 4; i++)
         if (i < wq.size() && wq[i] != exp[i]) mism++;
      chk(mism == 0, "R9 clipped rect addresses", mism, 0);
      run_cmd(3'b001, 220, 5, 0, 0, 8'h01, -1, -1);
      chk(cyc == 1 && wq.size() == 0, "R9 off-screen point", wq.size(), 0);
   endtask

   task automatic t_line(input int x0, input int y0, input int x1, input int y1);
      int adx = iabs(x1 - x0);
      int ady = iabs(y1 - y0);
      int n = ((adx > ady) ? adx : ady) + 1;
      int bad = 0;
      run_cmd(3'b010, x0, y0, x1, y1, 8'h05, -1, -1);
      chk(cyc == n, "R8 line busy cycles", cyc, n);
      chk(wq.size() == n, "R8 line write count", wq.size(), n);
      if (wq.size() > 0) begin
         chk(wq[0] == y0 * W + x0, "R8 line start", wq[0], y0 * W + x0);
         chk(wq[wq.size() - 1] == y1 * W + x1, "R8 line end", wq[wq.size() - 1], y1 * W + x1);
      end
      for (int i = 1; i < wq.size(); i++) begin
         int mx = iabs(wq[i] % W - wq[i - 1] % W);
         int my = iabs(wq[i] / W - wq[i - 1] / W);
         if (adx >= ady) begin
            if (mx != 1 || my > 1) bad++;
         end else begin
            if (my != 1 || mx > 1) bad++;
         end
      end
      chk(bad == 0, "R8 line step shape", bad, 0);
   endtask

   task automatic t_clear;
      int mism = 0;
      run_cmd(3'b000, 9, 9, 9, 9, 8'h0C, -1, -1);
      chk(cyc == W * H, "R6 clear busy cycles", cyc, W * H);
      chk(wq.size() == W * H, "R6 clear write count", wq.size(), W * H);
      for (int i = 0; i < wq.size(); i++)
         if (wq[i] != i) mism++;
      chk(mism == 0, "R6 clear ascending addresses", mism, 0);
      chk(colbad == 0, "R4 clear colour", colbad, 0);
   endtask

   task automatic t_ignore_busy;
      int mism = 0;
      int late = 0;
      run_cmd(3'b011, 50, 50, 53, 53, 8'h05, 2, 5);
      chk(cyc == 16, "R3 running rect length kept", cyc, 16);
      chk(wq.size() == 16 && colbad == 0, "R3 running rect colour kept", colbad, 0);
      for (int i = 0; i < wq.size(); i++)
         if (wq[i] != (50 + i / 4) * W + 50 + i % 4) mism++;
      chk(mism == 0, "R3 running rect pixels kept", mism, 0);
      for (int i = 0; i < 3; i++) begin
         if (busy || pix_we) late++;
         @(negedge clk);
      end
      chk(late == 0, "R3 no command after ignored strobe", late, 0);
   endtask

   initial begin
      #(20 * 200000);
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_point();
      t_reserved();
      t_rect(20, 30, 23, 32);
      t_rect(23, 32, 20, 30);
      t_rect(40, 10, 40, 12);
      t_clip();
      t_line(10, 10, 40, 20);
      t_line(40, 20, 10, 10);
      t_line(5, 50, 8, 10);
      t_line(30, 5, 10, 25);
      t_line(100, 100, 100, 100);
      t_line(0, 159, 213, 0);
      t_ignore_busy();
      t_clear();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule